// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small memory-mapped cluster of control registers that sits on a simple synchronous register bus. It holds byte-wide configuration, two auxiliary registers, a diagnostic byte and a modem-control byte. It also holds a 16-bit diagnostic LED register and a full-width system control word. A power-management location has no storage: a write there is a strobe. The bus carries an address, a write enable and write data. Read data is returned combinationally for the address currently presented.

A power-fail input can latch a pending flag in the second auxiliary register, but only while the configuration enable bit is set. The flag drives a level interrupt, and software clears it by writing to the same register. The block issues three single-cycle request pulses: a shutdown request from the auxiliary register, a system reset request from the system control word, and a CPU halt request from the power-management strobe.

The reset is partial. It clears the configuration, auxiliary and modem registers. The diagnostic byte, LED register and system control word keep their contents across it, so firmware can leave a trail that survives a warm restart.

Top module: `sysaux_ctrl`

## Requirements
- R1: The address is split into a window code in the upper WIN_W bits and an offset in the low OFF_W bits. The codes are: 1 configuration, 2 aux-A, 3 aux-B, 4 diagnostic, 5 modem control, 6 LED, 7 system control, 8 power management. Only offset 0 of a window is live. Any other code or offset reads 0 and ignores writes.
- R2: The configuration, aux-A, diagnostic and modem-control registers store bits 7:0 of a write and return them zero-extended on read.
- R3: While rst_n is low, the configuration, aux-A, aux-B and modem-control registers become 0 and all request pulses are low. The diagnostic, LED and system control registers keep their values.
- R4: On every clock edge where pwr_fail differs from its value at the previous edge, aux-B bit 2 (the pending flag) becomes pwr_fail AND configuration bit 3, using the configuration value held before that edge. The first edge after reset counts as a change if pwr_fail is high.
- R5: A write to aux-B stores data bit 0 as bit 0 and keeps bit 2 unchanged. If data bit 1 is 1, bit 2 is cleared. Bit 1 always reads 0. When the same edge also sees a pwr_fail change, R4 decides bit 2.
- R6: irq is high exactly when aux-B bit 2 and configuration bit 3 are both 1. It follows their registered values.
- R7: A write to aux-B with data bit 0 set makes shutdown_req high for exactly the one cycle after that write's clock edge.
- R8: A write to power management makes halt_req high for the one cycle after that write's edge. This location reads 0.
- R9: A write to system control with data bit 0 set loads the value 2 and makes sysrst_req high for the one cycle after that edge. A write with bit 0 clear changes nothing. The register reads back its full width.
- R10: The LED register stores bits 15:0 of a write and reads them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low partial reset |
| bus_addr | input | WIN_W+OFF_W | Window code and offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| pwr_fail | input | 1 | Power-fail level from the supply monitor |
| irq | output | 1 | Power-fail interrupt level |
| shutdown_req | output | 1 | One-cycle software shutdown request |
| sysrst_req | output | 1 | One-cycle system reset request |
| halt_req | output | 1 | One-cycle CPU halt request |

## Verification
The checker assumes that pwr_fail is synchronous to clk. A change is seen only at a clock edge, so a glitch shorter than a cycle is invisible by design. It also assumes that bus_we is low while reset is applied, because the pulse checks compare each request with the write one edge earlier. The stimulus changes pwr_fail and the bus only at the falling edge, and it drops the write strobe before each reset it inserts. Registers that reset does not clear are compared only after the bench has written them.

// File: rtl/sysaux_pkg.sv
package sysaux_pkg;

   localparam int NUM_WIN  = 8;
   localparam int CODE_W   = 4;
   localparam int NUM_BYTE = 4;
   localparam int NUM_REQ  = 3;

   typedef enum logic [2:0] {
      RID_CFG   = 3'd0,
      RID_AUXA  = 3'd1,
      RID_AUXB  = 3'd2,
      RID_DIAG  = 3'd3,
      RID_MODEM = 3'd4,
      RID_LED   = 3'd5,
      RID_SYSC  = 3'd6,
      RID_PWR   = 3'd7
   } rid_e;

   localparam int REQ_SHUT   = 0;
   localparam int REQ_SYSRST = 1;
   localparam int REQ_HALT   = 2;

   // bit b set: byte register b is not cleared by reset
   localparam logic [NUM_BYTE-1:0] BYTE_KEEP = 4'b0100;

   function automatic logic [CODE_W-1:0] win_code(input int idx);
      case (idx)
         0:       win_code = 4'h1;
         1:       win_code = 4'h2;
         2:       win_code = 4'h3;
         3:       win_code = 4'h4;
         4:       win_code = 4'h5;
         5:       win_code = 4'h6;
         6:       win_code = 4'h7;
         default: win_code = 4'h8;
      endcase
   endfunction

   // plain byte register slot -> window index
   function automatic int byte_rid(input int b);
      case (b)
         0:       byte_rid = int'(RID_CFG);
         1:       byte_rid = int'(RID_AUXA);
         2:       byte_rid = int'(RID_DIAG);
         default: byte_rid = int'(RID_MODEM);
      endcase
   endfunction

endpackage

// File: rtl/sysaux_decode.sv
module sysaux_decode
   import sysaux_pkg::*;
#(
   parameter int WIN_W = 4,
   parameter int OFF_W = 2,
   localparam int ADDR_W = WIN_W + OFF_W
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_WIN-1:0] hit
);

   logic [WIN_W-1:0] win;
   logic             off_zero;

   assign win      = addr[ADDR_W-1:OFF_W];
   assign off_zero = (addr[OFF_W-1:0] == '0);

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      assign hit[g] = off_zero && (win == WIN_W'(win_code(g)));
   end

endmodule

// File: rtl/sysaux_regs.sv
module sysaux_regs
   import sysaux_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LED_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NUM_BYTE-1:0]   hit_byte,
   input  logic                  hit_led,
   input  logic                  hit_sysc,
   output logic [NUM_BYTE*8-1:0] byte_flat,
   output logic [LED_W-1:0]      led_q,
   output logic [DATA_W-1:0]     sysc_q,
   output logic                  sysrst_trig
);

   localparam logic [DATA_W-1:0] SYSC_LOAD = DATA_W'(2);

   for (genvar b = 0; b < NUM_BYTE; b++) begin : g_byte
      logic [7:0] q;
      if (BYTE_KEEP[b]) begin : g_keep
         always_ff @(posedge clk) begin
            if (we && hit_byte[b]) q <= wdata[7:0];
         end
      end else begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 q <= '0;
            else if (we && hit_byte[b]) q <= wdata[7:0];
         end
      end
      assign byte_flat[b*8 +: 8] = q;
   end

   always_ff @(posedge clk) begin
      if (we && hit_led) led_q <= wdata[LED_W-1:0];
   end

   assign sysrst_trig = we && hit_sysc && wdata[0];

   always_ff @(posedge clk) begin
      if (sysrst_trig) sysc_q <= SYSC_LOAD;
   end

endmodule

// File: rtl/sysaux_pwrfail.sv
module sysaux_pwrfail (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pf_in,
   input  logic       pf_en,
   input  logic       wr,
   input  logic       wbit0,
   input  logic       wbit1,
   output logic [7:0] aux_byte,
   output logic       pf_evt,
   output logic       irq,
   output logic       shut_trig
);

   logic pf_q;
   logic pend_q, pend_d;
   logic off_q, off_d;

   assign pf_evt = pf_in ^ pf_q;

   always_comb begin
      pend_d = pend_q;
      off_d  = off_q;
      if (wr) begin
         off_d = wbit0;
         if (wbit1) pend_d = 1'b0;
      end
      if (pf_evt) pend_d = pf_in && pf_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf_q   <= 1'b0;
         pend_q <= 1'b0;
         off_q  <= 1'b0;
      end else begin
         pf_q   <= pf_in;
         pend_q <= pend_d;
         off_q  <= off_d;
      end
   end

   assign aux_byte  = {5'b0, pend_q, 1'b0, off_q};
   assign irq       = pend_q && pf_en;
   assign shut_trig = wr && wbit0;

endmodule

// File: rtl/sysaux_pulse.sv
module sysaux_pulse #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] trig,
   output logic [N-1:0] pulse
);

   for (genvar g = 0; g < N; g++) begin : g_pulse
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= trig[g];
      end
      assign pulse[g] = q;
   end

endmodule

// File: rtl/sysaux_ctrl.sv
module sysaux_ctrl
   import sysaux_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WIN_W  = 4,
   parameter int OFF_W  = 2,
   parameter int LED_W  = 16,
   localparam int ADDR_W = WIN_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pwr_fail,
   output logic              irq,
   output logic              shutdown_req,
   output logic              sysrst_req,
   output logic              halt_req
);

   if (DATA_W < 8 || DATA_W < LED_W) begin : g_bad_data
      $error("sysaux_ctrl: DATA_W must cover a byte and the LED width");
   end
   if (WIN_W < CODE_W) begin : g_bad_win
      $error("sysaux_ctrl: WIN_W too narrow for the window codes");
   end
   if (OFF_W < 1 || LED_W < 1) begin : g_bad_misc
      $error("sysaux_ctrl: OFF_W and LED_W must be positive");
   end

   logic [NUM_WIN-1:0]    hit;
   logic [NUM_BYTE-1:0]   hit_byte;
   logic [NUM_BYTE*8-1:0] byte_flat;
   logic [7:0]            cfg_q;
   logic [7:0]            aux_byte;
   logic [LED_W-1:0]      led_q;
   logic [DATA_W-1:0]     sysc_q;
   logic                  pf_evt;
   logic                  shut_trig;
   logic                  sysrst_trig;
   logic                  halt_trig;
   logic [NUM_REQ-1:0]    trig;
   logic [NUM_REQ-1:0]    pulse;

   sysaux_decode #(.WIN_W(WIN_W), .OFF_W(OFF_W)) u_decode (
      .addr (bus_addr),
      .hit  (hit)
   );

   for (genvar b = 0; b < NUM_BYTE; b++) begin : g_hsel
      assign hit_byte[b] = hit[byte_rid(b)];
   end

   sysaux_regs #(.DATA_W(DATA_W), .LED_W(LED_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (bus_we),
      .wdata       (bus_wdata),
      .hit_byte    (hit_byte),
      .hit_led     (hit[RID_LED]),
      .hit_sysc    (hit[RID_SYSC]),
      .byte_flat   (byte_flat),
      .led_q       (led_q),
      .sysc_q      (sysc_q),
      .sysrst_trig (sysrst_trig)
   );

   assign cfg_q = byte_flat[0 +: 8];

   sysaux_pwrfail u_pwrfail (
      .clk       (clk),
      .rst_n     (rst_n),
      .pf_in     (pwr_fail),
      .pf_en     (cfg_q[3]),
      .wr        (bus_we && hit[RID_AUXB]),
      .wbit0     (bus_wdata[0]),
      .wbit1     (bus_wdata[1]),
      .aux_byte  (aux_byte),
      .pf_evt    (pf_evt),
      .irq       (irq),
      .shut_trig (shut_trig)
   );

   assign halt_trig = bus_we && hit[RID_PWR];

   always_comb begin
      trig             = '0;
      trig[REQ_SHUT]   = shut_trig;
      trig[REQ_SYSRST] = sysrst_trig;
      trig[REQ_HALT]   = halt_trig;
   end

   sysaux_pulse #(.N(NUM_REQ)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (trig),
      .pulse (pulse)
   );

   assign shutdown_req = pulse[REQ_SHUT];
   assign sysrst_req   = pulse[REQ_SYSRST];
   assign halt_req     = pulse[REQ_HALT];

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BYTE; b++) begin
         if (hit_byte[b]) bus_rdata = DATA_W'(byte_flat[b*8 +: 8]);
      end
      if (hit[RID_AUXB]) bus_rdata = DATA_W'(aux_byte);
      if (hit[RID_LED])  bus_rdata = DATA_W'(led_q);
      if (hit[RID_SYSC]) bus_rdata = sysc_q;
   end

endmodule

// File: rtl/sysaux_ctrl_chk.sv
module sysaux_ctrl_chk
   import sysaux_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_we,
   input logic               wd0,
   input logic               wd1,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_WIN-1:0] hit,
   input logic               cfg_en,
   input logic               pend,
   input logic               pf_evt,
   input logic [DATA_W-1:0]  sysc_q,
   input logic               irq,
   input logic               shutdown_req,
   input logic               sysrst_req,
   input logic               halt_req
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (bus_rdata == '0)); // R1

   AST_PEND_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(pf_evt && !cfg_en)) |-> !pend); // R4

   AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(bus_we && hit[RID_AUXB] && wd1 && !pf_evt)) |-> !pend); // R5

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cfg_en); // R6

   AST_SHUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (shutdown_req == $past(bus_we && hit[RID_AUXB] && wd0))); // R7

   AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (halt_req == $past(bus_we && hit[RID_PWR]))); // R8

   AST_SYSRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (sysrst_req == $past(bus_we && hit[RID_SYSC] && wd0))); // R9

   AST_SYSC_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && sysrst_req) |-> (sysc_q == DATA_W'(2))); // R9

endmodule

bind sysaux_ctrl sysaux_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_we       (bus_we),
   .wd0          (bus_wdata[0]),
   .wd1          (bus_wdata[1]),
   .bus_rdata    (bus_rdata),
   .hit          (hit),
   .cfg_en       (cfg_q[3]),
   .pend         (aux_byte[2]),
   .pf_evt       (pf_evt),
   .sysc_q       (sysc_q),
   .irq          (irq),
   .shutdown_req (shutdown_req),
   .sysrst_req   (sysrst_req),
   .halt_req     (halt_req)
);

// File: tb/sysaux_ctrl_tb.sv
`timescale 1ns/1ps
module sysaux_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwr_fail = 1'b0;
   logic        irq, shutdown_req, sysrst_req, halt_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sysaux_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_we       (bus_we),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pwr_fail     (pwr_fail),
      .irq          (irq),
      .shutdown_req (shutdown_req),
      .sysrst_req   (sysrst_req),
      .halt_req     (halt_req)
   );

   // reference model
   logic [7:0]  m_cfg, m_auxa, m_diag, m_modem;
   logic        m_pend, m_off, m_pf;
   logic [15:0] m_led;
   logic [31:0] m_sysc;
   bit k_diag = 0, k_led = 0, k_sysc = 0;

   function automatic logic [5:0] adr(input int win, input int off);
      return {4'(win), 2'(off)};
   endfunction

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      if (a[1:0] != 2'd0) return '0;
      case (a[5:2])
         4'h1: return {24'b0, m_cfg};
         4'h2: return {24'b0, m_auxa};
         4'h3: return {29'b0, m_pend, 1'b0, m_off};
         4'h4: return {24'b0, m_diag};
         4'h5: return {24'b0, m_modem};
         4'h6: return {16'b0, m_led};
         4'h7: return m_sysc;
         default: return '0;
      endcase
   endfunction

   function automatic bit rd_known(input logic [5:0] a);
      if (a[1:0] != 2'd0) return 1'b1;
      case (a[5:2])
         4'h4: return k_diag;
         4'h6: return k_led;
         4'h7: return k_sysc;
         default: return 1'b1;
      endcase
   endfunction

   function automatic string rd_tag(input logic [5:0] a);
      if (a[1:0] != 2'd0) return "R1";
      case (a[5:2])
         4'h1, 4'h2, 4'h4, 4'h5: return "R2";
         4'h3: return "R5";
         4'h6: return "R10";
         4'h7: return "R9";
         4'h8: return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // one bus cycle: drive at falling edge, check read, step model, check outputs
   task automatic cyc(input logic [5:0] a, input logic we, input logic [31:0] wd,
                      input logic pf, input string rtag = "");
      logic e_shut, e_sys, e_halt, evt, live;
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_wdata = wd; pwr_fail = pf;
      #1;
      if (rd_known(a)) chk((rtag != "") ? rtag : rd_tag(a), bus_rdata, exp_rd(a));
      live   = (a[1:0] == 2'd0);
      e_shut = we && live && a[5:2] == 4'h3 && wd[0];
      e_sys  = we && live && a[5:2] == 4'h7 && wd[0];
      e_halt = we && live && a[5:2] == 4'h8;
      evt    = (pf != m_pf);
      if (we && live && a[5:2] == 4'h3) begin
         m_off = wd[0];
         if (wd[1]) m_pend = 1'b0;
      end
      if (evt) m_pend = pf && m_cfg[3];
      m_pf = pf;
      if (we && live) begin
         case (a[5:2])
            4'h1: m_cfg   = wd[7:0];
            4'h2: m_auxa  = wd[7:0];
            4'h4: begin m_diag = wd[7:0]; k_diag = 1; end
            4'h5: m_modem = wd[7:0];
            4'h6: begin m_led = wd[15:0]; k_led = 1; end
            4'h7: if (wd[0]) begin m_sysc = 32'd2; k_sysc = 1; end
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      chk("R7", {31'b0, shutdown_req}, {31'b0, e_shut});
      chk("R9", {31'b0, sysrst_req},   {31'b0, e_sys});
      chk("R8", {31'b0, halt_req},     {31'b0, e_halt});
      chk("R6", {31'b0, irq},          {31'b0, m_pend && m_cfg[3]});
   endtask

   task automatic do_reset();
      @(negedge clk);
      bus_we = 1'b0;
      rst_n = 1'b0;
      m_cfg = '0; m_auxa = '0; m_modem = '0; m_pend = 1'b0; m_off = 1'b0; m_pf = 1'b0;
      #1;
      chk("R3", {28'b0, shutdown_req, sysrst_req, halt_req, irq}, 32'b0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17C0DE));
      do_reset();
      // R3 reset values and R1 unmapped reads
      cyc(adr(1, 0), 0, 0, 0, "R3");
      cyc(adr(2, 0), 0, 0, 0, "R3");
      cyc(adr(3, 0), 0, 0, 0, "R3");
      cyc(adr(5, 0), 0, 0, 0, "R3");
      cyc(adr(0, 0), 0, 0, 0, "R1");
      cyc(adr(15, 0), 0, 0, 0, "R1");
      // R2 byte registers
      cyc(adr(1, 0), 1, 32'hFFFF_FFA5, 0);
      cyc(adr(2, 0), 1, 32'h0000_1177, 0);
      cyc(adr(4, 0), 1, 32'hABCD_EF3C, 0);
      cyc(adr(5, 0), 1, 32'h0000_00C3, 0);
      cyc(adr(1, 0), 0, 0, 0, "R2");
      cyc(adr(2, 0), 0, 0, 0, "R2");
      cyc(adr(4, 0), 0, 0, 0, "R2");
      cyc(adr(5, 0), 0, 0, 0, "R2");
      // R1 nonzero offsets ignored
      cyc(adr(1, 2), 1, 32'h0000_0000, 0);
      cyc(adr(1, 0), 0, 0, 0, "R1");
      cyc(adr(1, 1), 0, 0, 0, "R1");
      // R10 LED
      cyc(adr(6, 0), 1, 32'h1234_5678, 0);
      cyc(adr(6, 0), 0, 0, 0, "R10");
      cyc(adr(6, 1), 1, 32'h0000_FFFF, 0);
      cyc(adr(6, 0), 0, 0, 0, "R10");
      // R9 system control
      cyc(adr(7, 0), 1, 32'hFFFF_FFFE, 0);
      cyc(adr(7, 0), 1, 32'h0000_0001, 0);
      cyc(adr(7, 0), 0, 0, 0, "R9");
      cyc(adr(7, 0), 1, 32'hFFFF_FFFC, 0);
      cyc(adr(7, 0), 0, 0, 0, "R9");
      cyc(adr(7, 1), 0, 0, 0, "R9");
      // R8 power management strobe
      cyc(adr(8, 0), 1, 32'h0000_0000, 0);
      cyc(adr(8, 0), 0, 0, 0, "R8");
      cyc(adr(8, 3), 1, 32'h0000_0000, 0);
      // R4 power fail with enable clear: no pending
      cyc(adr(1, 0), 1, 32'h0000_0000, 0);
      cyc(adr(3, 0), 0, 0, 1);
      cyc(adr(3, 0), 0, 0, 1, "R4");
      cyc(adr(3, 0), 0, 0, 0, "R4");
      // R4/R6 enable set then fail
      cyc(adr(1, 0), 1, 32'h0000_0008, 0);
      cyc(adr(3, 0), 0, 0, 1);
      cyc(adr(3, 0), 0, 0, 1, "R4");
      cyc(adr(1, 0), 1, 32'h0000_0000, 1);
      cyc(adr(1, 0), 1, 32'h0000_0008, 1);
      // R5 write-to-clear, bit1 never stored
      cyc(adr(3, 0), 1, 32'h0000_0001, 1);
      cyc(adr(3, 0), 0, 0, 1, "R5");
      cyc(adr(3, 0), 1, 32'h0000_0003, 1);
      cyc(adr(3, 0), 0, 0, 1, "R5");
      cyc(adr(3, 0), 1, 32'h0000_0000, 0);
      cyc(adr(3, 0), 0, 0, 1, "R4");
      cyc(adr(3, 0), 0, 0, 0, "R4");
      // R3 partial reset retains diag, LED, system control
      do_reset();
      cyc(adr(4, 0), 0, 0, 0, "R3");
      cyc(adr(6, 0), 0, 0, 0, "R3");
      cyc(adr(7, 0), 0, 0, 0, "R3");
      cyc(adr(1, 0), 0, 0, 0, "R3");
      // constrained random
      for (int i = 0; i < 6000; i++) begin
         int win, off, sel;
         logic pf;
         sel = $urandom_range(0, 9);
         win = (sel < 8) ? $urandom_range(1, 8) : $urandom_range(0, 15);
         off = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : 0;
         pf  = ($urandom_range(0, 7) == 0) ? ~m_pf : m_pf;
         if (i % 1500 == 1499) do_reset();
         cyc(adr(win, off), 1'($urandom_range(0, 1)), $urandom, pf);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule